// File: doc/BRIEF.md
# Temperature Alarm with Consecutive-Fault Qualification

This block watches a stream of signed temperature conversion results and drives two alarm pins. The window alarm fires when a result lies above the high limit or below the low limit. The critical alarm fires when a result reaches the critical limit. Both alarms pass through a consecutive-fault counter, so a single noisy sample cannot trip them. Each alarm pin has its own programmable polarity. The two pins share one clearing discipline, which is either latched-until-read (interrupt mode) or hysteresis-gated (comparator mode).

Results arrive on a valid/ready interface. `res_ready` is held high at all times, so the block never applies back-pressure. A result is taken only in a cycle where `res_valid` is high. The limit, hysteresis and configuration words are plain control inputs that a register file elsewhere holds steady. The register-read strobe and the one-shot strobe are single-cycle pulses from that register file.

Temperatures use 16-bit two's complement with 7 fraction bits, so 128 LSB equal 1 degree. Hysteresis is a whole number of degrees and is scaled by 128 inside the block.

Top module: `temp_alarm`

## Requirements
- R1: `cfg[1:0]` sets the queue depth as 00=1, 01=2, 10=3 and 11=4. An alarm latches only on the accepted result that completes that many consecutive faulting results.
- R2: A result is a window fault when it is strictly greater than `lim_high` or strictly less than `lim_low`, compared as signed values. A result equal to either limit is not a fault.
- R3: A result is a critical fault when it is greater than or equal to `lim_crit`, compared as signed values.
- R4: An accepted result that is not a fault for a channel resets that channel's fault count to zero. The window channel and the critical channel count independently.
- R5: In interrupt mode (`cfg[4]`=1), a `reg_rd` pulse clears both latched alarms.
- R6: In comparator mode (`cfg[4]`=0), `reg_rd` has no effect. A latched alarm clears only on a `oneshot_wr` pulse while the most recent result is strictly below its own limit minus `hyst`×128. The window alarm uses `lim_high` and the critical alarm uses `lim_crit`.
- R7: `cfg[3]` sets the polarity of `int_o` and `cfg[2]` sets the polarity of `ct_o`. A bit value of 1 means active-high and 0 means active-low.
- R8: After reset both alarms are inactive and both fault counts are zero.
- R9: `res_ready` is always 1. Cycles with `res_valid`=0 change neither the fault counts nor the alarms, whatever value `res_temp` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Always high; the block never back-pressures |
| res_temp | input | 16 | Signed result, 7 fraction bits |
| lim_high | input | 16 | Signed high window limit |
| lim_low | input | 16 | Signed low window limit |
| lim_crit | input | 16 | Signed critical limit |
| hyst | input | 4 | Hysteresis in whole degrees |
| cfg | input | 8 | [1:0] queue depth, [2] critical polarity, [3] window polarity, [4] interrupt mode |
| reg_rd | input | 1 | Register-read pulse |
| oneshot_wr | input | 1 | One-shot write pulse |
| int_o | output | 1 | Window alarm pin |
| ct_o | output | 1 | Critical alarm pin |

## Verification
The bench sends fault runs that are exactly one short of each queue depth. A design with an off-by-one counter would trip early or late on those runs. It also breaks a run with one good sample; a counter that holds its count instead of resetting would trip too soon afterwards. Results placed exactly on the high, low and critical limits catch a mix-up between strict and inclusive comparisons and a loss of signedness with negative limits. The comparator-mode case sits one degree inside the hysteresis band, where a design that ignores the band would clear the alarm too early. The interrupt-mode case checks that a read clears both alarms, and a comparator-mode read confirms that reads do nothing there.

// File: rtl/ta_pkg.sv
package ta_pkg;
  localparam int TEMP_W   = 16;
  localparam int HYST_W   = 4;
  localparam int FRAC_W   = 7;
  localparam int QSEL_W   = 2;
  localparam int CFG_W    = 8;
  localparam int N_CH     = 2;
  localparam int CH_WIN   = 0;
  localparam int CH_CRIT  = 1;
  localparam int CFG_POL_CRIT = 2;
  localparam int CFG_POL_WIN  = 3;
  localparam int CFG_IRQ      = 4;
endpackage

// File: rtl/ta_fault_q.sv
module ta_fault_q #(
  parameter int QSEL_W = 2,
  localparam int MAXQ  = 1 << QSEL_W,
  localparam int CW    = QSEL_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          fault,
  input  logic [QSEL_W-1:0] qsel,
  output logic [CW-1:0] count,
  output logic          qualified
);
  logic [CW-1:0] depth;
  logic [CW-1:0] nxt;

  assign depth = CW'(qsel) + CW'(1);

  always_comb begin
    if (!fault)              nxt = '0;
    else if (count >= depth) nxt = depth;
    else                     nxt = count + CW'(1);
  end

  assign qualified = step && fault && (nxt == depth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= nxt;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(MAXQ)); // R1
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fault) |=> (count == '0)); // R4
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count)); // R9
endmodule

// File: rtl/ta_alarm_flag.sv
module ta_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic irq_mode,
  input  logic rd,
  input  logic oneshot,
  input  logic below_band,
  output logic flag
);
  logic nxt;

  always_comb begin
    nxt = flag;
    if (set)                                    nxt = 1'b1;
    else if (irq_mode && rd)                    nxt = 1'b0;
    else if (!irq_mode && oneshot && below_band) nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= nxt;
  end

  AST_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !flag ##1 flag |-> $past(set)); // R1
  AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && rd && !set) |=> !flag); // R5
  AST_CMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && !oneshot && flag) |=> flag); // R6
endmodule

// File: rtl/temp_alarm.sv
module temp_alarm
  import ta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [TEMP_W-1:0] res_temp,
  input  logic [TEMP_W-1:0] lim_high,
  input  logic [TEMP_W-1:0] lim_low,
  input  logic [TEMP_W-1:0] lim_crit,
  input  logic [HYST_W-1:0] hyst,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              reg_rd,
  input  logic              oneshot_wr,
  output logic              int_o,
  output logic              ct_o
);
  localparam int XW = TEMP_W + 2;

  logic signed [TEMP_W-1:0] t_s, hi_s, lo_s, cr_s;
  logic signed [TEMP_W-1:0] last_t;
  logic signed [XW-1:0]     hyst_x;
  logic [N_CH-1:0]          fault_c;
  logic [N_CH-1:0]          qual_c;
  logic [N_CH-1:0]          below_c;
  logic [N_CH-1:0]          flag_c;
  logic [N_CH-1:0]          pol_c;
  logic signed [XW-1:0]     ref_c [N_CH];

  assign res_ready = 1'b1;
  assign t_s  = res_temp;
  assign hi_s = lim_high;
  assign lo_s = lim_low;
  assign cr_s = lim_crit;
  assign hyst_x = XW'({hyst, {FRAC_W{1'b0}}});

  assign fault_c[CH_WIN]  = (t_s > hi_s) || (t_s < lo_s);
  assign fault_c[CH_CRIT] = (t_s >= cr_s);
  assign ref_c[CH_WIN]    = XW'(hi_s);
  assign ref_c[CH_CRIT]   = XW'(cr_s);
  assign pol_c[CH_WIN]    = cfg[CFG_POL_WIN];
  assign pol_c[CH_CRIT]   = cfg[CFG_POL_CRIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_t <= '0;
    else if (res_valid) last_t <= t_s;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [QSEL_W:0] cnt;

    assign below_c[c] = XW'(last_t) < (ref_c[c] - hyst_x);

    ta_fault_q #(.QSEL_W(QSEL_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (res_valid),
      .fault     (fault_c[c]),
      .qsel      (cfg[QSEL_W-1:0]),
      .count     (cnt),
      .qualified (qual_c[c])
    );

    ta_alarm_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (qual_c[c]),
      .irq_mode   (cfg[CFG_IRQ]),
      .rd         (reg_rd),
      .oneshot    (oneshot_wr),
      .below_band (below_c[c]),
      .flag       (flag_c[c])
    );
  end

  assign int_o = pol_c[CH_WIN]  ? flag_c[CH_WIN]  : ~flag_c[CH_WIN];
  assign ct_o  = pol_c[CH_CRIT] ? flag_c[CH_CRIT] : ~flag_c[CH_CRIT];

  AST_CRIT_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    qual_c[CH_CRIT] |-> (res_valid && (t_s >= cr_s))); // R3
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready); // R9
endmodule

// File: tb/temp_alarm_bench.sv
module temp_alarm_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] HI   = 16'd3840;   // 30 C
  localparam logic [15:0] LO   = -16'sd1280; // -10 C
  localparam logic [15:0] CR   = 16'd6400;   // 50 C
  localparam logic [15:0] HOT  = 16'd5120;   // 40 C
  localparam logic [15:0] OK_T = 16'd2560;   // 20 C

  logic clk = 0, rst_n = 0;
  logic res_valid = 0, res_ready;
  logic [15:0] res_temp = '0;
  logic [3:0]  hyst = 4'd2;
  logic [7:0]  cfg = 8'h0C;
  logic reg_rd = 0, oneshot_wr = 0;
  logic int_o, ct_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alarm u_temp_alarm (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_temp(res_temp), .lim_high(HI), .lim_low(LO), .lim_crit(CR),
    .hyst(hyst), .cfg(cfg), .reg_rd(reg_rd), .oneshot_wr(oneshot_wr),
    .int_o(int_o), .ct_o(ct_o));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] c);
    @(negedge clk); rst_n = 0; cfg = c; res_valid = 0; reg_rd = 0; oneshot_wr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic send(input logic [15:0] t);
    res_temp = t; res_valid = 1; @(negedge clk); res_valid = 0;
  endtask

  task automatic pulse_rd();    reg_rd = 1; @(negedge clk); reg_rd = 0; endtask
  task automatic pulse_shot();  oneshot_wr = 1; @(negedge clk); oneshot_wr = 0; endtask

  task automatic t_reset();
    do_reset(8'h0C);
    chk("R8 int after reset", int_o, 1'b0);
    chk("R8 ct after reset", ct_o, 1'b0);
    chk("R9 ready", res_ready, 1'b1);
  endtask

  task automatic t_depth(input int d);
    do_reset(8'h0C | 8'(d-1));
    for (int i = 0; i < d-1; i++) send(HOT);
    chk($sformatf("R1 depth %0d one short", d), int_o, 1'b0);
    send(HOT);
    chk($sformatf("R1 depth %0d reached", d), int_o, 1'b1);
    chk("R4 ct independent of window faults", ct_o, 1'b0);
  endtask

  task automatic t_break();
    do_reset(8'h0E);
    send(HOT); send(HOT); send(OK_T); send(HOT); send(HOT);
    chk("R4 broken run restarts", int_o, 1'b0);
    send(HOT);
    chk("R4 full run after break", int_o, 1'b1);
  endtask

  task automatic t_limits();
    do_reset(8'h0C);
    send(HI);
    chk("R2 equal high not fault", int_o, 1'b0);
    send(HI + 16'd1);
    chk("R2 above high", int_o, 1'b1);
    do_reset(8'h0C);
    send(LO);
    chk("R2 equal low not fault", int_o, 1'b0);
    send(LO - 16'd1);
    chk("R2 below negative low", int_o, 1'b1);
    do_reset(8'h0C);
    send(CR - 16'd1);
    chk("R3 just under crit", ct_o, 1'b0);
    send(CR);
    chk("R3 equal crit", ct_o, 1'b1);
  endtask

  task automatic t_irq();
    do_reset(8'h1C);
    send(CR);
    chk("R5 int set", int_o, 1'b1);
    chk("R5 ct set", ct_o, 1'b1);
    pulse_rd();
    chk("R5 read clears int", int_o, 1'b0);
    chk("R5 read clears ct", ct_o, 1'b0);
  endtask

  task automatic t_cmp();
    do_reset(8'h0C);
    send(CR);
    pulse_rd();
    chk("R6 read ignored int", int_o, 1'b1);
    chk("R6 read ignored ct", ct_o, 1'b1);
    send(16'd3712);            // 29 C
    chk("R6 no clear without shot", int_o, 1'b1);
    pulse_shot();
    chk("R6 int held inside band", int_o, 1'b1);
    chk("R6 ct cleared below crit-hyst", ct_o, 1'b0);
    send(16'd3456);            // 27 C
    chk("R6 int held before shot", int_o, 1'b1);
    pulse_shot();
    chk("R6 int cleared below high-hyst", int_o, 1'b0);
  endtask

  task automatic t_pol();
    do_reset(8'h00);
    chk("R7 int idle active-low", int_o, 1'b1);
    chk("R7 ct idle active-low", ct_o, 1'b1);
    send(HOT);
    chk("R7 int asserted low", int_o, 1'b0);
    chk("R7 ct stays idle", ct_o, 1'b1);
  endtask

  task automatic t_idle();
    do_reset(8'h0C);
    res_temp = CR;
    repeat (4) @(negedge clk);
    chk("R9 no valid no int", int_o, 1'b0);
    chk("R9 no valid no ct", ct_o, 1'b0);
  endtask

  initial begin
    t_reset();
    for (int d = 1; d <= 4; d++) t_depth(d);
    t_break();
    t_limits();
    t_irq();
    t_cmp();
    t_pol();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule